// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block is the front end of a small 8-bit controller whose program store sits on its own bus, apart from data memory. It holds the program counter, drives the program store address, and on every clock edge latches the returned 14-bit instruction word into an instruction register. That register feeds the execute stage. While execute works on one word, the sequencer is already fetching the next one, so straight-line code retires one instruction per cycle.

When execute resolves a taken branch, it raises `brTaken` together with `brTarget` for one cycle. The word being fetched in that cycle is thrown away. The next cycle is a bubble, with `instrValid` low, and fetch restarts at the target. A taken branch therefore occupies exactly two cycles. A branch request made during a bubble comes from no real instruction, so it is ignored. The program store depth is a parameter, and the counter width follows from it.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `progAddr` is 0 and `instrValid` is 0.
- R2: In a cycle where no branch is accepted, `progAddr` in the next cycle equals the current `progAddr` plus one.
- R3: Whenever `instrValid` is 1, `instrAddr` equals the `progAddr` of the previous cycle, and `instrWord` equals the word the program store returned at that address.
- R4: When `brTaken` is 1 while `instrValid` is 1, the next cycle has `instrValid` 0 (a bubble), and `progAddr` equals the `brTarget` sampled in the branch cycle.
- R5: A cycle with `instrValid` 0 is always followed by a cycle with `instrValid` 1. After a branch, that cycle executes the target address.
- R6: `brTaken` is ignored while `instrValid` is 0. Fetch continues sequentially and the next cycle is valid.
- R7: After the last address (`PROG_DEPTH-1`), the program counter wraps to address 0.
- R8: `PROG_DEPTH` may be 512, 1024 or 2048. `progAddr`, `instrAddr` and `brTarget` are log2(`PROG_DEPTH`) bits wide, and any other depth is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | log2(PROG_DEPTH) | Address sent to the program store in this cycle |
| progData | input | 14 | Word returned by the program store for `progAddr` in the same cycle |
| instrWord | output | 14 | Instruction word held for the execute stage |
| instrAddr | output | log2(PROG_DEPTH) | Program address of `instrWord` |
| instrValid | output | 1 | 1 when `instrWord` is a real instruction, 0 for a bubble |
| brTaken | input | 1 | Execute reports a taken branch for the current instruction |
| brTarget | input | log2(PROG_DEPTH) | Branch destination address |

## Verification
On every cycle, the in-line properties check four things: the counter steps by one (wrapping at the top), an accepted branch loads its target and produces exactly one bubble, every bubble is followed by a valid cycle, and a branch request during a bubble leaves the counter stepping. Only the bench scenarios can show that the executed address stream and the instruction words match a program image. These scenarios cover the reset cycle, branches placed back to back, a request made inside a bubble, and a run across the top of the address space. The bench also confirms the port widths that follow from the depth parameter.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  localparam int INSTR_W = 14;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic advance;      // step the program counter by one
    logic loadTarget;   // replace the program counter with the branch target
    logic captureValid; // the word latched at this edge is a real instruction
  } seqStrobe_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       brTaken,
  output seqStrobe_t strobe,
  output logic       execValid
);

  logic validQ;
  logic takeBranch;

  // A request only counts when a real instruction is in execute
  assign takeBranch = brTaken && validQ;

  always_comb begin
    strobe              = '0;
    strobe.loadTarget   = takeBranch;
    strobe.advance      = !takeBranch;
    strobe.captureValid = !takeBranch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.captureValid;
  end

  assign execValid = validQ;

  AST_BUBBLE_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && validQ) |=> !validQ); // R4

  AST_BUBBLE_IS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |=> validQ); // R5

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int PROG_DEPTH = 2048,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [PC_W-1:0]    brTarget,
  input  logic [INSTR_W-1:0] progData,
  output logic [PC_W-1:0]    progAddr,
  output logic [INSTR_W-1:0] instrWord,
  output logic [PC_W-1:0]    instrAddr
);

  localparam logic [PC_W-1:0] LAST_ADDR = PC_W'(PROG_DEPTH - 1);

  logic [PC_W-1:0]    pcQ, pcStep, pcD;
  logic [INSTR_W-1:0] irQ;
  logic [PC_W-1:0]    irAddrQ;

  assign pcStep = (pcQ == LAST_ADDR) ? '0 : pcQ + 1'b1;

  always_comb begin
    pcD = pcQ;
    if (strobe.loadTarget)   pcD = brTarget;
    else if (strobe.advance) pcD = pcStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= '0;
      irQ     <= '0;
      irAddrQ <= '0;
    end else begin
      pcQ     <= pcD;
      irQ     <= progData;
      irAddrQ <= pcQ;
    end
  end

  assign progAddr  = pcQ;
  assign instrWord = irQ;
  assign instrAddr = irAddrQ;

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.loadTarget) |=>
      pcQ == (($past(pcQ) == LAST_ADDR) ? '0 : PC_W'($past(pcQ) + 1'b1))); // R2

  AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (pcQ == LAST_ADDR && !strobe.loadTarget) |=> pcQ == '0); // R7

  AST_PC_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTarget |=> pcQ == $past(brTarget)); // R4

  AST_EXEC_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureValid |=> irAddrQ == $past(pcQ) && irQ == $past(progData)); // R3

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int PROG_DEPTH = 2048,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progData,
  output logic [INSTR_W-1:0] instrWord,
  output logic [PC_W-1:0]    instrAddr,
  output logic               instrValid,
  input  logic               brTaken,
  input  logic [PC_W-1:0]    brTarget
);

  // R8: only the three supported store sizes elaborate
  generate
    if (PROG_DEPTH != 512 && PROG_DEPTH != 1024 && PROG_DEPTH != 2048) begin : g_badDepth
      $error("fetch_seq: unsupported PROG_DEPTH");
    end
  endgenerate

  seqStrobe_t strobe;

  fetch_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .brTaken   (brTaken),
    .strobe    (strobe),
    .execValid (instrValid)
  );

  fetch_seq_dp #(.PROG_DEPTH(PROG_DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .brTarget  (brTarget),
    .progData  (progData),
    .progAddr  (progAddr),
    .instrWord (instrWord),
    .instrAddr (instrAddr)
  );

  AST_IDLE_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && !instrValid) |=> instrValid && progAddr == PC_W'($past(progAddr) + 1'b1)); // R6

endmodule

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb_top;

  localparam int DEPTH = 512;
  localparam int PC_W  = $clog2(DEPTH);

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] execAddr;
    logic [13:0]     word;
    logic [PC_W-1:0] fetchAddr;
    logic [3:0]      tag;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] progAddr;
  logic [13:0]     progData;
  logic [13:0]     instrWord;
  logic [PC_W-1:0] instrAddr;
  logic            instrValid;
  logic            brTaken = 1'b0;
  logic [PC_W-1:0] brTarget = '0;

  logic [13:0] progMem [DEPTH];
  expItem_t    expQ [$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  bit              mValid = 1'b0;
  logic [PC_W-1:0] mExec = '0;
  logic [PC_W-1:0] mPc = '0;
  logic [3:0]      mTag = 4'd1;

  always #4 clk = ~clk;

  initial for (int a = 0; a < DEPTH; a++) progMem[a] = 14'((a * 37 + 5) ^ (a << 5));
  assign progData = progMem[progAddr];

  fetch_seq #(.PROG_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData),
    .instrWord(instrWord), .instrAddr(instrAddr), .instrValid(instrValid),
    .brTaken(brTaken), .brTarget(brTarget)
  );

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expectation for the current cycle mid-cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(tagName(it.tag), "instrValid", int'(instrValid), int'(it.valid));
      check(tagName(it.tag), "progAddr", int'(progAddr), int'(it.fetchAddr));
      if (it.valid) begin
        check(tagName(it.tag), "instrAddr", int'(instrAddr), int'(it.execAddr));
        check("R3", "instrWord", int'(instrWord), int'(it.word));
      end
    end
  end

  // Driver: sets inputs for the current cycle, pushes its expectation, advances the model
  task automatic step(input bit br, input int tgt);
    bit taken;
    expItem_t it;
    brTaken  = br;
    brTarget = PC_W'(tgt);
    it.valid = mValid;
    it.execAddr = mExec;
    it.word = progMem[mExec];
    it.fetchAddr = mPc;
    it.tag = mTag;
    expQ.push_back(it);
    taken = br && mValid;
    if (taken) mTag = 4'd4;                    // R4 bubble next
    else if (br && !mValid) mTag = 4'd6;       // R6 ignored request
    else if (!mValid) mTag = 4'd5;             // R5 valid after bubble
    else if (mPc == PC_W'(DEPTH - 1)) mTag = 4'd7; // R7 wrap
    else mTag = 4'd2;                          // R2 sequential
    mValid = !taken;
    mExec  = mPc;
    mPc    = taken ? PC_W'(tgt) : PC_W'(mPc + 1'b1);
    @(posedge clk); #1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: widths follow the depth parameter
    check("R8", "progAddr width", $bits(progAddr), 9);
    check("R8", "instrAddr width", $bits(instrAddr), 9);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "progAddr in reset", int'(progAddr), 0);
    check("R1", "instrValid in reset", int'(instrValid), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    run(6);                   // R1 first cycle, then R2/R3 straight line
    step(1'b1, 100);          // R4 taken branch
    step(1'b1, 7);            // R6 request inside the bubble
    run(4);                   // R5 target executes, sequential continues
    step(1'b1, 508);
    run(8);                   // R7 wrap past 511
    step(1'b1, 511);
    step(1'b0, 0);            // bubble
    step(1'b1, 20);           // branch at the first valid target cycle
    step(1'b1, 40);           // request in bubble, ignored
    run(3);
    step(1'b1, 30);
    step(1'b0, 0);
    step(1'b1, 60);           // back-to-back taken branches
    step(1'b0, 0);
    run(5);
    @(negedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule